// File: doc/BRIEF.md
# Multi-Master AHB-Lite Merge Arbiter

This block lets several AHB-Lite managers share one downstream AHB-Lite subordinate. In every address phase it picks one requesting manager and forwards that manager's address and control. The winner is recorded as the owner of the next data phase. The subordinate's ready, read data and response then go back to that owner only, and the owner's write data is forwarded downstream.

A manager can present a transfer while another manager holds the bus. It then sees ready high and believes its address phase was taken. The block stores that address phase in a per-manager holding register and issues it downstream later. Until the stored transfer has been issued and completed, the manager sees ready low.

A manager that neither owns the current data phase nor has a stored transfer always sees ready high. The first transfer after reset or an idle period therefore passes straight through with no wait state. This holds even though no real previous data phase exists.

Top module: `ahb_lite_merge`

## Requirements
- R1: After reset, every manager sees ready high, no manager owns a data phase, and the downstream transfer type is IDLE (HTRANS encoding: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ; bit 1 set means a transfer request).
- R2: When several managers request in the same cycle and the downstream address phase is free, the lowest-indexed manager's address phase is forwarded, and at most one manager is granted per cycle.
- R3: A manager that owns no data phase and has no stored transfer sees ready high. Its first request after idle is forwarded downstream in the same cycle it is presented.
- R4: The manager that owns the current data phase sees the downstream ready unchanged.
- R5: A manager that does not own the current data phase receives all-zero read data and a zero response.
- R6: A request that is not accepted downstream in its own cycle is kept and forwarded later, with the same address, direction and size.
- R7: Once a request of a manager has been taken but not accepted downstream, that manager sees ready low until the stored transfer has been forwarded and its data phase has completed.
- R8: While a downstream address phase with a NONSEQ or SEQ transfer type is stalled by ready low, the downstream address, transfer type and direction stay unchanged in the next cycle.
- R9: When no manager requests and no transfer is stored, the downstream transfer type is IDLE.
- R10: Downstream write data is taken from the manager that owns the current data phase.
- R11: The owner of a read data phase receives the subordinate's read data when ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mHaddr | input | N*ADDR_W | Address from each manager |
| mHtrans | input | N*2 | Transfer type from each manager |
| mHwrite | input | N | Write direction from each manager |
| mHsize | input | N*3 | Transfer size from each manager |
| mHwdata | input | N*DATA_W | Write data from each manager |
| mHrdata | output | N*DATA_W | Read data to each manager, zero unless owner |
| mHresp | output | N | Response to each manager, zero unless owner |
| mHreadyOut | output | N | Ready to each manager |
| sHaddr | output | ADDR_W | Forwarded address |
| sHtrans | output | 2 | Forwarded transfer type |
| sHwrite | output | 1 | Forwarded direction |
| sHsize | output | 3 | Forwarded size |
| sHwdata | output | DATA_W | Write data of the data-phase owner |
| sHrdata | input | DATA_W | Read data from the subordinate |
| sHresp | input | 1 | Response from the subordinate |
| sHreadyOut | input | 1 | Ready from the subordinate |

## Verification
The difficult overlap happens when one manager is stalled in its data phase while another manager presents a new address phase. In that single cycle, the new request must be captured into its holding register and presented downstream. The owner must also see the low ready, and the newcomer must see ready high. A directed sequence forces this overlap with a fixed two-cycle subordinate wait. It then checks, cycle by cycle, the forwarded address, its stability during the stall, each manager's ready and the zeroed read data of the non-owner. Randomized traffic from three managers with random gaps and random wait states repeats the overlap many times. Each manager reads its own address region, so every read must return what that manager last wrote. A held transfer that is lost, duplicated or corrupted would show up as wrong read data.

// File: rtl/ahb_merge_pkg.sv
package ahb_merge_pkg;

  localparam int HSIZE_W = 3;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } transKind_t;

  // Per-lane strobes from control to datapath
  typedef struct packed {
    logic grant;    // lane drives the downstream address phase now
    logic useHold;  // take the address phase from the holding register
    logic load;     // capture the live address phase into the holding register
    logic owner;    // lane owns the current data phase
  } laneStrobe_t;

endpackage

// File: rtl/merge_ctrl.sv
module merge_ctrl import ahb_merge_pkg::*; #(
  parameter int N = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [N-1:0]            liveTransHi,
  input  logic                    sHreadyOut,
  output laneStrobe_t [N-1:0]     strobe,
  output logic [N-1:0]            mHreadyOut
);

  logic [N-1:0] holdValid;
  logic [N-1:0] ownerQ;
  logic [N-1:0] grantQ;
  logic         stuckQ;

  logic [N-1:0] liveReq;
  logic [N-1:0] req;
  logic [N-1:0] pick;
  logic [N-1:0] grant;
  logic [N-1:0] accepted;
  logic         found;

  // Ready seen by each lane: owner follows downstream, pending lane waits, others free
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (ownerQ[i])        mHreadyOut[i] = sHreadyOut;
      else if (holdValid[i]) mHreadyOut[i] = 1'b0;
      else                  mHreadyOut[i] = 1'b1;
    end
  end

  assign liveReq = liveTransHi & mHreadyOut;
  assign req     = holdValid | liveReq;

  // Fixed priority, lowest index first
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign grant    = stuckQ ? grantQ : pick;
  assign accepted = grant & {N{sHreadyOut}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= '0;
      ownerQ    <= '0;
      grantQ    <= '0;
      stuckQ    <= 1'b0;
    end else begin
      holdValid <= req & ~accepted;
      grantQ    <= grant;
      stuckQ    <= (|grant) & ~sHreadyOut;
      if (sHreadyOut) ownerQ <= grant;
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_strobe
      assign strobe[g].grant   = grant[g];
      assign strobe[g].useHold = holdValid[g];
      assign strobe[g].load    = liveReq[g] & ~holdValid[g];
      assign strobe[g].owner   = ownerQ[g];
    end
  endgenerate

endmodule

// File: rtl/merge_datapath.sv
module merge_datapath import ahb_merge_pkg::*; #(
  parameter int N      = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  laneStrobe_t [N-1:0]             strobe,
  input  logic [N-1:0][ADDR_W-1:0]        mHaddr,
  input  logic [N-1:0][1:0]               mHtrans,
  input  logic [N-1:0]                    mHwrite,
  input  logic [N-1:0][HSIZE_W-1:0]       mHsize,
  input  logic [N-1:0][DATA_W-1:0]        mHwdata,
  output logic [N-1:0][DATA_W-1:0]        mHrdata,
  output logic [N-1:0]                    mHresp,
  output logic [ADDR_W-1:0]               sHaddr,
  output logic [1:0]                      sHtrans,
  output logic                            sHwrite,
  output logic [HSIZE_W-1:0]              sHsize,
  output logic [DATA_W-1:0]               sHwdata,
  input  logic [DATA_W-1:0]               sHrdata,
  input  logic                            sHresp
);

  logic [N-1:0][ADDR_W-1:0]  holdAddr;
  logic [N-1:0][1:0]         holdTrans;
  logic [N-1:0]              holdWrite;
  logic [N-1:0][HSIZE_W-1:0] holdSize;

  generate
    for (genvar g = 0; g < N; g++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          holdAddr[g]  <= '0;
          holdTrans[g] <= TR_IDLE;
          holdWrite[g] <= 1'b0;
          holdSize[g]  <= '0;
        end else if (strobe[g].load) begin
          holdAddr[g]  <= mHaddr[g];
          holdTrans[g] <= mHtrans[g];
          holdWrite[g] <= mHwrite[g];
          holdSize[g]  <= mHsize[g];
        end
      end

      assign mHrdata[g] = strobe[g].owner ? sHrdata : '0;
      assign mHresp[g]  = strobe[g].owner & sHresp;
    end
  endgenerate

  // One-hot OR multiplexers for address phase and write data
  always_comb begin
    sHaddr  = '0;
    sHtrans = TR_IDLE;
    sHwrite = 1'b0;
    sHsize  = '0;
    sHwdata = '0;
    for (int i = 0; i < N; i++) begin
      if (strobe[i].grant) begin
        if (strobe[i].useHold) begin
          sHaddr  = sHaddr  | holdAddr[i];
          sHtrans = sHtrans | holdTrans[i];
          sHwrite = sHwrite | holdWrite[i];
          sHsize  = sHsize  | holdSize[i];
        end else begin
          sHaddr  = sHaddr  | mHaddr[i];
          sHtrans = sHtrans | mHtrans[i];
          sHwrite = sHwrite | mHwrite[i];
          sHsize  = sHsize  | mHsize[i];
        end
      end
      if (strobe[i].owner) sHwdata = sHwdata | mHwdata[i];
    end
  end

endmodule

// File: rtl/ahb_lite_merge.sv
module ahb_lite_merge import ahb_merge_pkg::*; #(
  parameter int N      = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [N-1:0][ADDR_W-1:0]        mHaddr,
  input  logic [N-1:0][1:0]               mHtrans,
  input  logic [N-1:0]                    mHwrite,
  input  logic [N-1:0][HSIZE_W-1:0]       mHsize,
  input  logic [N-1:0][DATA_W-1:0]        mHwdata,
  output logic [N-1:0][DATA_W-1:0]        mHrdata,
  output logic [N-1:0]                    mHresp,
  output logic [N-1:0]                    mHreadyOut,
  output logic [ADDR_W-1:0]               sHaddr,
  output logic [1:0]                      sHtrans,
  output logic                            sHwrite,
  output logic [HSIZE_W-1:0]              sHsize,
  output logic [DATA_W-1:0]               sHwdata,
  input  logic [DATA_W-1:0]               sHrdata,
  input  logic                            sHresp,
  input  logic                            sHreadyOut
);

  laneStrobe_t [N-1:0] strobe;
  logic [N-1:0]        liveTransHi;
  logic [N-1:0]        grantVec;
  logic [N-1:0]        ownerVec;
  logic [N-1:0]        holdVec;

  generate
    for (genvar g = 0; g < N; g++) begin : g_tap
      assign liveTransHi[g] = mHtrans[g][1];
      assign grantVec[g]    = strobe[g].grant;
      assign ownerVec[g]    = strobe[g].owner;
      assign holdVec[g]     = strobe[g].useHold;
    end
  endgenerate

  merge_ctrl #(.N(N)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .liveTransHi (liveTransHi),
    .sHreadyOut  (sHreadyOut),
    .strobe      (strobe),
    .mHreadyOut  (mHreadyOut)
  );

  merge_datapath #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .mHaddr  (mHaddr),
    .mHtrans (mHtrans),
    .mHwrite (mHwrite),
    .mHsize  (mHsize),
    .mHwdata (mHwdata),
    .mHrdata (mHrdata),
    .mHresp  (mHresp),
    .sHaddr  (sHaddr),
    .sHtrans (sHtrans),
    .sHwrite (sHwrite),
    .sHsize  (sHsize),
    .sHwdata (sHwdata),
    .sHrdata (sHrdata),
    .sHresp  (sHresp)
  );

endmodule

// File: rtl/merge_checker.sv
module merge_checker #(
  parameter int N      = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [N-1:0][1:0]         mHtrans,
  input logic [N-1:0][DATA_W-1:0]  mHrdata,
  input logic [N-1:0]              mHresp,
  input logic [N-1:0]              mHreadyOut,
  input logic [ADDR_W-1:0]         sHaddr,
  input logic [1:0]                sHtrans,
  input logic                      sHwrite,
  input logic                      sHreadyOut,
  input logic [N-1:0]              grantVec,
  input logic [N-1:0]              ownerVec,
  input logic [N-1:0]              holdVec
);

  logic seen;
  logic [N-1:0] liveHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  always_comb begin
    for (int i = 0; i < N; i++) liveHi[i] = mHtrans[i][1];
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  // R8
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sHtrans[1] && !sHreadyOut) |=>
      (sHaddr == $past(sHaddr)) && (sHtrans == $past(sHtrans)) && (sHwrite == $past(sHwrite)));

  // R9
  idle_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveHi == '0 && holdVec == '0) |-> (sHtrans == 2'b00));

  generate
    for (genvar g = 0; g < N; g++) begin : g_lane_chk
      // R3
      free_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
        (seen && $past(sHreadyOut) && ($past(grantVec) == '0) && !holdVec[g]) |-> mHreadyOut[g]);

      // R4
      owner_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
        (seen && $past(sHreadyOut) && $past(grantVec[g])) |-> (mHreadyOut[g] == sHreadyOut));

      // R5
      gated_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
        !ownerVec[g] |-> ((mHrdata[g] == '0) && !mHresp[g]));

      // R7
      pending_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
        (mHtrans[g][1] && mHreadyOut[g] && !(grantVec[g] && sHreadyOut)) |=> !mHreadyOut[g]);
    end
  endgenerate

endmodule

bind ahb_lite_merge merge_checker #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_merge_checker (
  .clk        (clk),
  .rstN       (rstN),
  .mHtrans    (mHtrans),
  .mHrdata    (mHrdata),
  .mHresp     (mHresp),
  .mHreadyOut (mHreadyOut),
  .sHaddr     (sHaddr),
  .sHtrans    (sHtrans),
  .sHwrite    (sHwrite),
  .sHreadyOut (sHreadyOut),
  .grantVec   (grantVec),
  .ownerVec   (ownerVec),
  .holdVec    (holdVec)
);

// File: tb/test_ahb_lite_merge.sv
module test_ahb_lite_merge;
  import ahb_merge_pkg::*;

  localparam int N      = 3;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rstN;

  logic [N-1:0][ADDR_W-1:0]  mHaddr;
  logic [N-1:0][1:0]         mHtrans;
  logic [N-1:0]              mHwrite;
  logic [N-1:0][HSIZE_W-1:0] mHsize;
  logic [N-1:0][DATA_W-1:0]  mHwdata;
  logic [N-1:0][DATA_W-1:0]  mHrdata;
  logic [N-1:0]              mHresp;
  logic [N-1:0]              mHreadyOut;
  logic [ADDR_W-1:0]         sHaddr;
  logic [1:0]                sHtrans;
  logic                      sHwrite;
  logic [HSIZE_W-1:0]        sHsize;
  logic [DATA_W-1:0]         sHwdata;
  logic [DATA_W-1:0]         sHrdata;
  logic                      sHresp;
  logic                      sHreadyOut;

  ahb_lite_merge #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ahb_lite_merge (
    .clk(clk), .rstN(rstN),
    .mHaddr(mHaddr), .mHtrans(mHtrans), .mHwrite(mHwrite), .mHsize(mHsize),
    .mHwdata(mHwdata), .mHrdata(mHrdata), .mHresp(mHresp), .mHreadyOut(mHreadyOut),
    .sHaddr(sHaddr), .sHtrans(sHtrans), .sHwrite(sHwrite), .sHsize(sHsize),
    .sHwdata(sHwdata), .sHrdata(sHrdata), .sHresp(sHresp), .sHreadyOut(sHreadyOut)
  );

  // Subordinate model: 16 words, programmable wait states
  logic [31:0] mem [16];
  logic        dpValid, dpWrite;
  logic [3:0]  dpIdx;
  int          waitLeft;
  int          waitMode;   // negative: random 0..3, else fixed

  assign sHreadyOut = !(dpValid && waitLeft != 0);
  assign sHrdata    = (dpValid && !dpWrite) ? mem[dpIdx] : '0;
  assign sHresp     = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      dpValid  <= 1'b0;
      dpWrite  <= 1'b0;
      dpIdx    <= '0;
      waitLeft <= 0;
      for (int k = 0; k < 16; k++) mem[k] <= 32'h1000 + k * 32'h01010101;
    end else begin
      if (dpValid && waitLeft != 0) waitLeft <= waitLeft - 1;
      else if (dpValid && dpWrite)  mem[dpIdx] <= sHwdata;
      if (sHreadyOut) begin
        dpValid  <= sHtrans[1];
        dpIdx    <= sHaddr[5:2];
        dpWrite  <= sHwrite;
        waitLeft <= (waitMode < 0) ? int'($urandom_range(0, 3)) : waitMode;
      end
    end
  end

  logic [31:0] expMem [16];
  int nCmp = 0;
  int nBad = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(int id, logic [31:0] addr, bit wr, logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    mHaddr[id]  = addr;
    mHtrans[id] = TR_NONSEQ;
    mHwrite[id] = wr;
    mHsize[id]  = 3'd2;
    forever begin
      #1;
      if (mHreadyOut[id]) break;
      @(negedge clk);
    end
    @(negedge clk);
    mHtrans[id] = TR_IDLE;
    mHwdata[id] = wd;
    forever begin
      #1;
      if (mHreadyOut[id]) break;
      @(negedge clk);
    end
    rd = mHrdata[id];
  endtask

  task automatic randomLane(int id);
    logic [31:0] rd;
    for (int k = 0; k < 25; k++) begin
      int gap;
      int idx;
      bit wr;
      logic [31:0] wd;
      gap = $urandom_range(0, 2);
      repeat (gap) @(negedge clk);
      idx = id * 4 + int'($urandom_range(0, 3));
      wr  = 1'($urandom_range(0, 1));
      wd  = $urandom;
      xfer(id, 32'(idx * 4), wr, wd, rd);
      if (wr) expMem[idx] = wd;
      else    chk("R11 random read data", rd, expMem[idx]);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd0, rd1, rd2;
    void'($urandom(32'd1234));
    for (int k = 0; k < 16; k++) expMem[k] = 32'h1000 + k * 32'h01010101;
    waitMode = 0;
    mHaddr = '0; mHtrans = '0; mHwrite = '0; mHsize = '0; mHwdata = '0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset ready", 32'(mHreadyOut), 32'b111);
    chk("R1 reset trans", 32'(sHtrans), 32'(TR_IDLE));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ready after reset", 32'(mHreadyOut), 32'b111);

    // First transfer after idle: forwarded at once, no wait state
    fork
      xfer(0, 32'h0, 1'b0, '0, rd0);
      begin
        @(negedge clk); #2;
        chk("R3 first ready", 32'(mHreadyOut[0]), 1);
        chk("R3 first trans", 32'(sHtrans), 32'(TR_NONSEQ));
        chk("R3 first addr", sHaddr, 32'h0);
        @(negedge clk); #2;
        chk("R4 owner ready", 32'(mHreadyOut[0]), 1);
        chk("R11 direct rdata", mHrdata[0], expMem[0]);
      end
    join
    chk("R11 first read", rd0, expMem[0]);

    // Contention: lanes 1 and 2 request together
    fork
      xfer(1, 32'd16, 1'b1, 32'hA1A1_0001, rd1);
      xfer(2, 32'd32, 1'b1, 32'hB2B2_0002, rd2);
      begin
        @(negedge clk); #2;
        chk("R2 winner addr", sHaddr, 32'd16);
        chk("R2 winner trans", 32'(sHtrans), 32'(TR_NONSEQ));
        chk("R3 loser ready", 32'(mHreadyOut[2]), 1);
        @(negedge clk); #2;
        chk("R6 replay addr", sHaddr, 32'd32);
        chk("R6 replay write", 32'(sHwrite), 1);
        chk("R7 pending ready", 32'(mHreadyOut[2]), 0);
        chk("R4 owner ready", 32'(mHreadyOut[1]), 1);
        chk("R10 wdata lane1", sHwdata, 32'hA1A1_0001);
        @(negedge clk); #2;
        chk("R10 wdata lane2", sHwdata, 32'hB2B2_0002);
        chk("R7 replay done ready", 32'(mHreadyOut[2]), 1);
        chk("R9 idle", 32'(sHtrans), 32'(TR_IDLE));
      end
    join
    expMem[4] = 32'hA1A1_0001;
    expMem[8] = 32'hB2B2_0002;
    repeat (2) @(negedge clk);

    // Stalled owner while another lane issues
    waitMode = 2;
    fork
      xfer(0, 32'd4, 1'b0, '0, rd0);
      begin @(negedge clk); xfer(1, 32'd20, 1'b0, '0, rd1); end
      begin
        @(negedge clk); #2;
        chk("R3 stall start addr", sHaddr, 32'd4);
        @(negedge clk); #2;
        chk("R4 owner sees wait", 32'(mHreadyOut[0]), 0);
        chk("R3 newcomer ready", 32'(mHreadyOut[1]), 1);
        chk("R2 newcomer addr", sHaddr, 32'd20);
        @(negedge clk); #2;
        chk("R8 stable addr", sHaddr, 32'd20);
        chk("R8 stable trans", 32'(sHtrans), 32'(TR_NONSEQ));
        chk("R7 newcomer waits", 32'(mHreadyOut[1]), 0);
        @(negedge clk); #2;
        chk("R4 owner done", 32'(mHreadyOut[0]), 1);
        chk("R11 owner rdata", mHrdata[0], expMem[1]);
        chk("R5 non-owner rdata", mHrdata[1], 32'h0);
        chk("R5 non-owner resp", 32'(mHresp[1]), 0);
        @(negedge clk); #2;
        chk("R4 new owner waits", 32'(mHreadyOut[1]), 0);
      end
    join
    chk("R11 stalled read", rd0, expMem[1]);
    chk("R6 held read", rd1, expMem[5]);
    xfer(2, 32'd32, 1'b0, '0, rd2);
    chk("R6 replayed write landed", rd2, expMem[8]);

    // Random traffic with random wait states
    waitMode = -1;
    fork
      randomLane(0);
      randomLane(1);
      randomLane(2);
    join
    repeat (4) @(negedge clk);
    #2;
    chk("R9 final idle", 32'(sHtrans), 32'(TR_IDLE));
    summary();
    $finish;
  end

endmodule